// File: doc/BRIEF.md
# Audio DAC Input Source Selector

This block decides which stereo sample stream reaches the DAC datapath. There are three candidates: two external serial data inputs (A and B), and an internal loopback path that carries ADC samples back into the DAC. Each source delivers left/right pairs of 24-bit signed samples, and a single-cycle valid strobe marks each pair. A frame-boundary strobe marks where one left/right frame ends and the next begins.

Control settings take effect in two ways:
- The source choice and the loopback enable are committed only on a frame boundary. A partial pair therefore never reaches the DAC.
- The DAC interface-format field drives the effective format while loopback is off. While loopback is on, the field is ignored and writes to it are deferred until loopback is cleared.

The ADC interface-format bit always passes through to the serial output format. During a clocking change the DAC output is forced to zero. Zero data stays forced for one full frame after the change completes.

Top module: `dac_source_select`

## Requirements
- R1: After reset, input A is selected, loopback is off, `dacFmtEff` is 00, `dacLeft`, `dacRight` and `dacValid` are 0, and `zeroActive` is 0.
- R2: With loopback off, committed `srcSelB`=0 routes A and committed `srcSelB`=1 routes B to the DAC outputs.
- R3: With loopback committed on, the ADC samples and their valid strobe are routed to the DAC outputs, whatever the value of `srcSelB`.
- R4: `srcSelB` and `loopEn` are committed only at a clock edge where `frameTick` is 1. Changes made between boundaries do not alter which source is routed.
- R5: While committed loopback is off, `dacFmtEff` equals the value `dacFmtIn` held at the previous clock edge.
- R6: While committed loopback is on, `dacFmtEff` holds its value, whatever is written to `dacFmtIn`.
- R7: One clock edge after committed loopback clears, `dacFmtEff` takes the current `dacFmtIn` value, including any value written during loopback.
- R8: `sdoutFmt` equals the value `adcFmtIn` held at the previous clock edge, whether loopback is on or off.
- R9: While `clkChange` is 1, `zeroActive` is 1 in the same cycle, and every pair output at the next edge has zero left and right data (the valid strobe still passes).
- R10: After `clkChange` returns to 0, zero forcing continues through the first `frameTick` edge and ends at the second. Data passes from the edge after that.
- R11: `dacValid` is 1 for exactly the one cycle after the selected source's valid strobe. `dacLeft` and `dacRight` are updated at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcSelB | input | 1 | External source choice: 0 = A, 1 = B |
| loopEn | input | 1 | Loopback enable: route ADC samples to the DAC |
| dacFmtIn | input | 2 | Requested DAC interface format |
| adcFmtIn | input | 1 | ADC interface format bit |
| clkChange | input | 1 | High while a clocking mode change is under way |
| frameTick | input | 1 | Left/right frame boundary strobe |
| aValid | input | 1 | Input A pair valid |
| aLeft | input | 24 | Input A left sample |
| aRight | input | 24 | Input A right sample |
| bValid | input | 1 | Input B pair valid |
| bLeft | input | 24 | Input B left sample |
| bRight | input | 24 | Input B right sample |
| adcValid | input | 1 | ADC pair valid |
| adcLeft | input | 24 | ADC left sample |
| adcRight | input | 24 | ADC right sample |
| dacValid | output | 1 | Output pair valid strobe |
| dacLeft | output | 24 | Left sample to the DAC |
| dacRight | output | 24 | Right sample to the DAC |
| dacFmtEff | output | 2 | DAC interface format in effect |
| sdoutFmt | output | 1 | Format applied to the serial data output |
| zeroActive | output | 1 | High while DAC data is forced to zero |

## Verification
The assertions assume that `frameTick` is a single-cycle pulse and that `clkChange` is a level held across several cycles. They also assume each source raises its valid strobe for one cycle per pair. The stimulus drives every control change and every valid pulse one step after a rising edge. Frame ticks are issued on cycles of their own, apart from sample strobes, so every commit point is unambiguous. `dacFmtIn` is written only while the loopback state is settled, never on the same edge that commits a loopback change, except where deferral is the point under test.

// File: rtl/dacsel_pkg.sv
package dacsel_pkg;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic selB;       // committed external choice
    logic loopOn;     // committed loopback
    logic forceZero;  // zero the samples
  } dacsel_ctl_t;

  typedef enum logic [1:0] {
    Z_PASS = 2'd0,
    Z_WAIT = 2'd1,
    Z_HOLD = 2'd2
  } zero_state_e;

endpackage

// File: rtl/dacsel_ctrl.sv
module dacsel_ctrl
  import dacsel_pkg::*;
#(
  parameter int FmtW = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            srcSelB,
  input  logic            loopEn,
  input  logic [FmtW-1:0] dacFmtIn,
  input  logic            adcFmtIn,
  input  logic            clkChange,
  input  logic            frameTick,
  output dacsel_ctl_t     ctl,
  output logic [FmtW-1:0] dacFmtEff,
  output logic            sdoutFmt
);

  logic        selReg;
  logic        loopReg;
  zero_state_e zState;
  zero_state_e zNext;

  // Commit selection only on frame boundaries
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReg  <= 1'b0;
      loopReg <= 1'b0;
    end else if (frameTick) begin
      selReg  <= srcSelB;
      loopReg <= loopEn;
    end
  end

  // Format: track request unless loopback holds it back
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dacFmtEff <= '0;
      sdoutFmt  <= 1'b0;
    end else begin
      sdoutFmt <= adcFmtIn;
      if (!loopReg) dacFmtEff <= dacFmtIn;
    end
  end

  // Zero-forcing sequencer
  always_comb begin
    zNext = zState;
    unique case (zState)
      Z_PASS: if (clkChange) zNext = Z_WAIT;
      Z_WAIT: if (!clkChange && frameTick) zNext = Z_HOLD;
      Z_HOLD: begin
        if (clkChange)      zNext = Z_WAIT;
        else if (frameTick) zNext = Z_PASS;
      end
      default: zNext = Z_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) zState <= Z_PASS;
    else       zState <= zNext;
  end

  always_comb begin
    ctl.selB      = selReg;
    ctl.loopOn    = loopReg;
    ctl.forceZero = clkChange || (zState != Z_PASS);
  end

  // R4: committed settings move only at frame ticks
  p_sel_frame_r4: assert property (@(posedge clk) disable iff (!rstN)
    !frameTick |=> $stable(selReg) && $stable(loopReg));

  // R6: format frozen while loopback committed
  p_fmt_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    loopReg |=> $stable(dacFmtEff));

  // R5: format follows request otherwise
  p_fmt_track_r5: assert property (@(posedge clk) disable iff (!rstN)
    !loopReg |=> dacFmtEff == $past(dacFmtIn));

  // R10: release of clkChange does not end zeroing at once
  p_release_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkChange) |-> ctl.forceZero);

  // R8: serial output format follows ADC bit
  p_sdout_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> sdoutFmt == $past(adcFmtIn));

endmodule

// File: rtl/dacsel_path.sv
module dacsel_path
  import dacsel_pkg::*;
#(
  parameter int SampleW = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  dacsel_ctl_t        ctl,
  input  logic               aValid,
  input  logic [SampleW-1:0] aLeft,
  input  logic [SampleW-1:0] aRight,
  input  logic               bValid,
  input  logic [SampleW-1:0] bLeft,
  input  logic [SampleW-1:0] bRight,
  input  logic               adcValid,
  input  logic [SampleW-1:0] adcLeft,
  input  logic [SampleW-1:0] adcRight,
  output logic               dacValid,
  output logic [SampleW-1:0] dacLeft,
  output logic [SampleW-1:0] dacRight
);

  localparam int PairW = 2 * SampleW;

  logic             extValid;
  logic [PairW-1:0] extPair;
  logic             selValid;
  logic [PairW-1:0] selPair;

  always_comb begin
    extValid = ctl.selB ? bValid : aValid;
    extPair  = ctl.selB ? {bLeft, bRight} : {aLeft, aRight};
    selValid = ctl.loopOn ? adcValid : extValid;
    selPair  = ctl.loopOn ? {adcLeft, adcRight} : extPair;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dacValid <= 1'b0;
      dacLeft  <= '0;
      dacRight <= '0;
    end else begin
      dacValid <= selValid;
      if (selValid) begin
        if (ctl.forceZero) begin
          dacLeft  <= '0;
          dacRight <= '0;
        end else begin
          dacLeft  <= selPair[PairW-1:SampleW];
          dacRight <= selPair[SampleW-1:0];
        end
      end
    end
  end

  // R9: zeroed pairs while forcing is requested
  p_zero_out_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.forceZero && selValid |=> dacLeft == '0 && dacRight == '0);

  // R11: strobe follows chosen source by one cycle
  p_valid_r11: assert property (@(posedge clk) disable iff (!rstN)
    selValid |=> dacValid);

  // R3: loopback pair reaches output
  p_loop_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loopOn && adcValid && !ctl.forceZero |=> dacLeft == $past(adcLeft));

endmodule

// File: rtl/dac_source_select.sv
module dac_source_select
  import dacsel_pkg::*;
#(
  parameter int SampleW = 24,
  parameter int FmtW    = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               srcSelB,
  input  logic               loopEn,
  input  logic [FmtW-1:0]    dacFmtIn,
  input  logic               adcFmtIn,
  input  logic               clkChange,
  input  logic               frameTick,
  input  logic               aValid,
  input  logic [SampleW-1:0] aLeft,
  input  logic [SampleW-1:0] aRight,
  input  logic               bValid,
  input  logic [SampleW-1:0] bLeft,
  input  logic [SampleW-1:0] bRight,
  input  logic               adcValid,
  input  logic [SampleW-1:0] adcLeft,
  input  logic [SampleW-1:0] adcRight,
  output logic               dacValid,
  output logic [SampleW-1:0] dacLeft,
  output logic [SampleW-1:0] dacRight,
  output logic [FmtW-1:0]    dacFmtEff,
  output logic               sdoutFmt,
  output logic               zeroActive
);

  dacsel_ctl_t ctl;

  dacsel_ctrl #(.FmtW(FmtW)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .srcSelB   (srcSelB),
    .loopEn    (loopEn),
    .dacFmtIn  (dacFmtIn),
    .adcFmtIn  (adcFmtIn),
    .clkChange (clkChange),
    .frameTick (frameTick),
    .ctl       (ctl),
    .dacFmtEff (dacFmtEff),
    .sdoutFmt  (sdoutFmt)
  );

  dacsel_path #(.SampleW(SampleW)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .aValid   (aValid),
    .aLeft    (aLeft),
    .aRight   (aRight),
    .bValid   (bValid),
    .bLeft    (bLeft),
    .bRight   (bRight),
    .adcValid (adcValid),
    .adcLeft  (adcLeft),
    .adcRight (adcRight),
    .dacValid (dacValid),
    .dacLeft  (dacLeft),
    .dacRight (dacRight)
  );

  assign zeroActive = ctl.forceZero;

endmodule

// File: tb/dac_source_select_bench.sv
module dac_source_select_bench;

  localparam int SW = 24;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          srcSelB = 1'b0, loopEn = 1'b0, adcFmtIn = 1'b0;
  logic          clkChange = 1'b0, frameTick = 1'b0;
  logic [1:0]    dacFmtIn = 2'b00;
  logic          aValid = 1'b0, bValid = 1'b0, adcValid = 1'b0;
  logic [SW-1:0] aLeft = '0, aRight = '0, bLeft = '0, bRight = '0;
  logic [SW-1:0] adcLeft = '0, adcRight = '0;
  logic          dacValid, sdoutFmt, zeroActive;
  logic [SW-1:0] dacLeft, dacRight;
  logic [1:0]    dacFmtEff;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  dac_source_select u_dac_source_select (
    .clk(clk), .rstN(rstN), .srcSelB(srcSelB), .loopEn(loopEn),
    .dacFmtIn(dacFmtIn), .adcFmtIn(adcFmtIn), .clkChange(clkChange),
    .frameTick(frameTick),
    .aValid(aValid), .aLeft(aLeft), .aRight(aRight),
    .bValid(bValid), .bLeft(bLeft), .bRight(bRight),
    .adcValid(adcValid), .adcLeft(adcLeft), .adcRight(adcRight),
    .dacValid(dacValid), .dacLeft(dacLeft), .dacRight(dacRight),
    .dacFmtEff(dacFmtEff), .sdoutFmt(sdoutFmt), .zeroActive(zeroActive)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic commitTick();
    frameTick = 1'b1;
    step();
    frameTick = 1'b0;
  endtask

  task automatic loadSamples(input int k);
    aLeft   = 24'h100000 + SW'(k);  aRight   = 24'h110000 + SW'(k);
    bLeft   = 24'h200000 + SW'(k);  bRight   = 24'h220000 + SW'(k);
    adcLeft = 24'h300000 + SW'(k);  adcRight = 24'h330000 + SW'(k);
  endtask

  task automatic pulseAll();
    aValid = 1'b1; bValid = 1'b1; adcValid = 1'b1;
    step();
    aValid = 1'b0; bValid = 1'b0; adcValid = 1'b0;
  endtask

  // {srcSelB, loopEn, expected source: 0=A 1=B 2=ADC}
  localparam logic [3:0] VECS [6] = '{
    {1'b0, 1'b0, 2'd0}, {1'b1, 1'b0, 2'd1}, {1'b0, 1'b1, 2'd2},
    {1'b1, 1'b1, 2'd2}, {1'b1, 1'b0, 2'd1}, {1'b0, 1'b0, 2'd0}
  };

  initial begin
    logic [SW-1:0] expL, expR;
    repeat (3) step();
    // R1: reset state
    check("R1 valid", 48'(dacValid), 48'(0));
    check("R1 data", {dacLeft, dacRight}, 48'(0));
    check("R1 fmt", 48'(dacFmtEff), 48'(0));
    check("R1 zero", 48'(zeroActive), 48'(0));
    rstN = 1'b1;
    step();
    loadSamples(0);
    pulseAll();
    check("R1 input A routed after reset", {dacLeft, dacRight}, {aLeft, aRight});

    // Vector walk: R2 and R3
    for (int i = 0; i < 6; i++) begin
      srcSelB = VECS[i][3];
      loopEn  = VECS[i][2];
      commitTick();
      loadSamples(i + 1);
      pulseAll();
      case (VECS[i][1:0])
        2'd0:    begin expL = aLeft;   expR = aRight;   end
        2'd1:    begin expL = bLeft;   expR = bRight;   end
        default: begin expL = adcLeft; expR = adcRight; end
      endcase
      check(VECS[i][1:0] == 2'd2 ? "R3 loopback route" : "R2 ext route",
            {dacLeft, dacRight}, {expL, expR});
      check("R11 strobe high", 48'(dacValid), 48'(1));
      step();
      check("R11 strobe single", 48'(dacValid), 48'(0));
    end

    // R11: only selected source's strobe counts (A committed, B pulses)
    bValid = 1'b1; step(); bValid = 1'b0;
    check("R11 unselected strobe", 48'(dacValid), 48'(0));

    // R4: change without frame tick has no effect
    srcSelB = 1'b1; loopEn = 1'b1;
    step();
    loadSamples(40);
    pulseAll();
    check("R4 no commit", {dacLeft, dacRight}, {aLeft, aRight});
    commitTick();
    loadSamples(41);
    pulseAll();
    check("R4 commit at tick", {dacLeft, dacRight}, {adcLeft, adcRight});
    loopEn = 1'b0; srcSelB = 1'b0;
    commitTick();

    // R5: format tracks when loopback off
    dacFmtIn = 2'b10;
    step();
    check("R5 fmt track", 48'(dacFmtEff), 48'(2'b10));
    // Enter loopback, then write format
    loopEn = 1'b1;
    commitTick();
    dacFmtIn = 2'b01;
    repeat (3) step();
    check("R6 fmt held in loopback", 48'(dacFmtEff), 48'(2'b10));
    adcFmtIn = 1'b1;
    step();
    check("R8 sdout fmt in loopback", 48'(sdoutFmt), 48'(1));
    loopEn = 1'b0;
    commitTick();
    check("R6 fmt held on clearing edge", 48'(dacFmtEff), 48'(2'b10));
    step();
    check("R7 deferred fmt applied", 48'(dacFmtEff), 48'(2'b01));
    dacFmtIn = 2'b11; adcFmtIn = 1'b0;
    step();
    check("R5 fmt track again", 48'(dacFmtEff), 48'(2'b11));
    check("R8 sdout fmt follows", 48'(sdoutFmt), 48'(0));

    // R9: clocking change forces zero
    clkChange = 1'b1;
    #1;
    check("R9 zeroActive", 48'(zeroActive), 48'(1));
    loadSamples(50);
    pulseAll();
    check("R9 zero data", {dacLeft, dacRight}, 48'(0));
    check("R9 strobe passes", 48'(dacValid), 48'(1));
    clkChange = 1'b0;
    step();
    check("R10 still zero after release", 48'(zeroActive), 48'(1));
    pulseAll();
    check("R10 zero data before ticks", {dacLeft, dacRight}, 48'(0));
    commitTick();
    check("R10 zero after first tick", 48'(zeroActive), 48'(1));
    pulseAll();
    check("R10 zero data in hold frame", {dacLeft, dacRight}, 48'(0));
    commitTick();
    check("R10 released after full frame", 48'(zeroActive), 48'(0));
    loadSamples(51);
    pulseAll();
    check("R10 data passes again", {dacLeft, dacRight}, {aLeft, aRight});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule